// File: doc/BRIEF.md
# Multi-CPU System Interrupt Router

This block gathers 32 hardware interrupt lines from the rest of the system and decides which processor interrupt levels they raise, and on which processor. Each line is copied into a pending register on every clock, so pending follows the line and is not latched. A disable register masks individual sources. Its top bit is a master switch that blocks every hardware source at once. Every source that is both pending and enabled is translated into one of fifteen processor levels through a fixed per-source table. The set of levels that results is delivered to exactly one processor, the one named by a programmable target register.

Software reaches the block through a small word-addressed register port with full 32-bit data. Through it, software reads pending, disable and target, sets and clears disable bits through separate offsets, and retargets the hardware interrupts. The outputs are one registered 16-bit level vector per processor, intended for a per-processor combiner that merges them with local interrupts. There is also a broadcast flag that follows the level-15 sources for all processors, whatever the disable state.

Top module: `irq_router`

## Requirements
- R1: The pending register takes the value of the source lines one clock after they change. Sources 23, 24, 25, 26 and 31 have no level and never become pending.
- R2: A read at word offset 0 returns the pending register, with bit 31 always 0.
- R3: Only disable bits inside mask 0xF05DFF80 can be written. A read at offset 1 returns the disable register ANDed with that mask. The bits of 0x0FA2007F stay disabled whatever is written.
- R4: A write at offset 2 clears every writable disable bit that is 1 in the data. This enables those sources.
- R5: A write at offset 3 sets every writable disable bit that is 1 in the data. The pending register is unchanged.
- R6: A write at offset 4 loads the target register from data bits [3:0]. A read at offset 4 returns the target, zero-extended.
- R7: A pending, enabled source raises its level bit in the target's vector. CPU c owns bits [16c+15:16c] of cpu_lvl_o. The level of each source is: level 2 for sources 0 and 7; level 3 for 1 and 8; level 5 for 2 and 9; level 7 for 3 and 10; level 9 for 4, 11 and 21; level 11 for 5, 12 and 22; level 13 for 6, 13 and 17; level 12 for 14 and 15; level 6 for 16; level 4 for 18; level 10 for 19; level 8 for 20; level 15 for 27 to 30. The vector updates two clocks after a source change and one clock after a register write.
- R8: At most one CPU's vector is nonzero, and only the CPU whose index equals the target register receives levels.
- R9: While disable bit 31 (master disable) is set, every CPU vector is 0.
- R10: Reset (synchronous, active high) leaves pending at 0, target at 0, the disable register at 0x0FA2007F, all vectors at 0 and the broadcast flag at 0.
- R11: lvl15_bcast_o is 1, one clock after any of sources 27 to 30 is high. The disable register has no effect on it.
- R12: Reads at offsets 5, 6 and 7 return 0. Writes there change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Hardware interrupt source lines, level sensitive |
| reg_sel_i | input | 3 | Register word offset |
| reg_we_i | input | 1 | Write strobe for the selected offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the selected offset (combinational) |
| cpu_lvl_o | output | NUM_CPU*16 | Registered level vector, 16 bits per CPU |
| lvl15_bcast_o | output | 1 | Level-15 broadcast flag for all CPUs |

## Verification
A single routable source checks the table lookup and the register placement of the target CPU. A wide burst of sources checks that several levels are ORed together, and a burst made only of level-less sources checks that they never become pending. Sources that are disabled forever, master disable with other masks set, and selective enabling separate the three gating paths from one another. Retargeting, level-15 sources while disabled, and writes to unused offsets each test one claim: the vector moves with the target, the broadcast ignores the disable register, and unused offsets change nothing.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int SRC_N   = 32;
    localparam int LVL_N   = 16;
    localparam int TGT_W   = 4;
    localparam int OFF_W   = 3;
    localparam int MSTR_B  = 31;

    // Disable bits that reset to 1 and can never be written
    localparam logic [SRC_N-1:0] DIS_FIXED = 32'h0FA2_007F;
    localparam logic [SRC_N-1:0] DIS_WMASK = ~DIS_FIXED;

    typedef enum logic [OFF_W-1:0] {
        OFF_PEND  = 3'd0,
        OFF_DISRD = 3'd1,
        OFF_ENA   = 3'd2,
        OFF_DIS   = 3'd3,
        OFF_TGT   = 3'd4
    } reg_off_e;

    typedef struct packed {
        logic [SRC_N-1:0] dis;
        logic [TGT_W-1:0] tgt;
    } ctrl_state_t;

    // Processor level that each source bit drives; 0 means no level
    function automatic logic [3:0] src_level(input int idx);
        logic [3:0] l;
        case (idx)
            0, 7:          l = 4'd2;
            1, 8:          l = 4'd3;
            2, 9:          l = 4'd5;
            3, 10:         l = 4'd7;
            4, 11, 21:     l = 4'd9;
            5, 12, 22:     l = 4'd11;
            6, 13, 17:     l = 4'd13;
            14, 15:        l = 4'd12;
            16:            l = 4'd6;
            18:            l = 4'd4;
            19:            l = 4'd10;
            20:            l = 4'd8;
            27, 28, 29, 30: l = 4'd15;
            default:       l = 4'd0;
        endcase
        return l;
    endfunction

    function automatic logic [SRC_N-1:0] live_mask();
        logic [SRC_N-1:0] m;
        for (int j = 0; j < SRC_N; j++) m[j] = (src_level(j) != 4'd0);
        return m;
    endfunction

    function automatic logic [SRC_N-1:0] top_mask();
        logic [SRC_N-1:0] m;
        for (int j = 0; j < SRC_N; j++) m[j] = (src_level(j) == 4'd15);
        return m;
    endfunction

endpackage

// File: rtl/irq_pend_capture.sv
module irq_pend_capture
    import irq_route_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_N-1:0] src_i,
    output logic [SRC_N-1:0] pend_o,
    output logic             top_o
);
    localparam logic [SRC_N-1:0] LIVE = live_mask();
    localparam logic [SRC_N-1:0] TOP  = top_mask();

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_o <= '0;
            top_o  <= 1'b0;
        end else begin
            pend_o <= src_i & LIVE;
            top_o  <= |(src_i & TOP);
        end
    end
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
    import irq_route_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OFF_W-1:0] sel_i,
    input  logic             we_i,
    input  logic [SRC_N-1:0] wdata_i,
    input  logic [SRC_N-1:0] pend_i,
    output ctrl_state_t      st_o,
    output logic [SRC_N-1:0] rdata_o
);
    ctrl_state_t st_q;
    logic [SRC_N-1:0] wbits;

    assign wbits = wdata_i & DIS_WMASK;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.dis <= DIS_FIXED;
            st_q.tgt <= '0;
        end else if (we_i) begin
            case (sel_i)
                OFF_ENA: st_q.dis <= st_q.dis & ~wbits;
                OFF_DIS: st_q.dis <= st_q.dis | wbits;
                OFF_TGT: st_q.tgt <= wdata_i[TGT_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (sel_i)
            OFF_PEND:  rdata_o = {1'b0, pend_i[SRC_N-2:0]};
            OFF_DISRD: rdata_o = st_q.dis & DIS_WMASK;
            OFF_TGT:   rdata_o = {{(SRC_N-TGT_W){1'b0}}, st_q.tgt};
            default:   rdata_o = '0;
        endcase
    end

    assign st_o = st_q;
endmodule

// File: rtl/irq_level_map.sv
module irq_level_map
    import irq_route_pkg::*;
(
    input  logic [SRC_N-1:0] pend_i,
    input  logic [SRC_N-1:0] dis_i,
    output logic [LVL_N-1:0] lvl_o
);
    logic [SRC_N-1:0] en;
    logic [LVL_N-1:0] raw;

    assign en = pend_i & ~dis_i;

    always_comb begin
        raw = '0;
        for (int j = 0; j < SRC_N; j++) begin
            if (en[j]) raw[src_level(j)] = 1'b1;
        end
        raw[0] = 1'b0;
        lvl_o = dis_i[MSTR_B] ? '0 : raw;
    end
endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_route_pkg::*;
#(
    parameter int NUM_CPU = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [31:0]              src_i,
    input  logic [2:0]               reg_sel_i,
    input  logic                     reg_we_i,
    input  logic [31:0]              reg_wdata_i,
    output logic [31:0]              reg_rdata_o,
    output logic [NUM_CPU*16-1:0]    cpu_lvl_o,
    output logic                     lvl15_bcast_o
);
    localparam int VEC_W = NUM_CPU * LVL_N;

    logic [SRC_N-1:0] pend_w;
    logic [SRC_N-1:0] dis_w;
    logic [TGT_W-1:0] tgt_w;
    logic [LVL_N-1:0] hw_lvl;
    ctrl_state_t      st_w;

    irq_pend_capture u_cap (
        .clk    (clk),
        .rst    (rst),
        .src_i  (src_i),
        .pend_o (pend_w),
        .top_o  (lvl15_bcast_o)
    );

    irq_ctrl_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .sel_i   (reg_sel_i),
        .we_i    (reg_we_i),
        .wdata_i (reg_wdata_i),
        .pend_i  (pend_w),
        .st_o    (st_w),
        .rdata_o (reg_rdata_o)
    );

    assign dis_w = st_w.dis;
    assign tgt_w = st_w.tgt;

    irq_level_map u_map (
        .pend_i (pend_w),
        .dis_i  (dis_w),
        .lvl_o  (hw_lvl)
    );

    logic [VEC_W-1:0] lvl_q;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        always_ff @(posedge clk) begin
            if (rst) lvl_q[c*LVL_N +: LVL_N] <= '0;
            else     lvl_q[c*LVL_N +: LVL_N] <= (int'(tgt_w) == c) ? hw_lvl : '0;
        end
    end

    assign cpu_lvl_o = lvl_q;
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
    import irq_route_pkg::*;
#(
    parameter int NUM_CPU = 16
) (
    input logic                  clk,
    input logic                  rst,
    input logic [31:0]           src_i,
    input logic [2:0]            reg_sel_i,
    input logic                  reg_we_i,
    input logic [31:0]           reg_wdata_i,
    input logic [31:0]           reg_rdata_o,
    input logic [NUM_CPU*16-1:0] cpu_lvl_o,
    input logic                  lvl15_bcast_o,
    input logic [31:0]           dis_w,
    input logic [3:0]            tgt_w
);
    localparam logic [31:0] LIVE = live_mask();
    localparam logic [31:0] TOP  = top_mask();

    logic past_ok;
    logic [NUM_CPU-1:0] nz;

    always_ff @(posedge clk) past_ok <= !rst;

    always_comb begin
        for (int c = 0; c < NUM_CPU; c++) nz[c] = |cpu_lvl_o[c*16 +: 16];
    end

    // R1
    pend_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && reg_sel_i == 3'd0) |-> reg_rdata_o == ($past(src_i) & LIVE));
    // R2
    pend_msb_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_sel_i == 3'd0) |-> !reg_rdata_o[31]);
    // R3
    dis_read_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_sel_i == 3'd1) |-> (reg_rdata_o & DIS_FIXED) == 32'd0);
    // R3
    dis_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (dis_w & DIS_FIXED) == DIS_FIXED);
    // R4
    enable_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we_i && reg_sel_i == 3'd2) |=> (dis_w & $past(reg_wdata_i) & DIS_WMASK) == 32'd0);
    // R5
    disable_set_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we_i && reg_sel_i == 3'd3) |=>
            (dis_w & $past(reg_wdata_i) & DIS_WMASK) == ($past(reg_wdata_i) & DIS_WMASK));
    // R6
    tgt_write_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we_i && reg_sel_i == 3'd4) |=> tgt_w == $past(reg_wdata_i[3:0]));
    // R8
    one_target_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(nz));
    // R9
    master_off_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(dis_w[31])) |-> cpu_lvl_o == '0);
    // R10
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (dis_w == DIS_FIXED && tgt_w == 4'd0 && cpu_lvl_o == '0));
    // R11
    bcast_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> lvl15_bcast_o == |($past(src_i) & TOP));
    // R12
    undef_read_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_sel_i > 3'd4) |-> reg_rdata_o == 32'd0);
endmodule

bind irq_router irq_router_chk #(.NUM_CPU(NUM_CPU)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .src_i         (src_i),
    .reg_sel_i     (reg_sel_i),
    .reg_we_i      (reg_we_i),
    .reg_wdata_i   (reg_wdata_i),
    .reg_rdata_o   (reg_rdata_o),
    .cpu_lvl_o     (cpu_lvl_o),
    .lvl15_bcast_o (lvl15_bcast_o),
    .dis_w         (dis_w),
    .tgt_w         (tgt_w)
);

// File: tb/irq_router_test.sv
module irq_router_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCPU = 16;
    localparam int NV = NCPU * 16;
    localparam logic [31:0] WM   = 32'hF05D_FF80;
    localparam logic [31:0] FIX  = 32'h0FA2_007F;
    localparam logic [31:0] LIVE = 32'h787F_FFFF;
    localparam logic [31:0] L15  = 32'h7800_0000;
    localparam int TBL [32] = '{2,3,5,7,9,11,13,2,3,5,7,9,11,13,12,12,
                                6,13,4,10,8,9,11,0,0,0,0,15,15,15,15,0};

    logic clk = 1'b0, rst = 1'b1;
    logic [31:0] src = '0;
    logic [2:0]  sel = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NV-1:0] lvl;
    logic bcast;

    irq_router #(.NUM_CPU(NCPU)) uut (
        .clk(clk), .rst(rst), .src_i(src), .reg_sel_i(sel), .reg_we_i(we),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .cpu_lvl_o(lvl),
        .lvl15_bcast_o(bcast)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int            kind;   // 0 vector, 1 broadcast, 2 register read
        logic [2:0]    rsel;
        logic [NV-1:0] exp;
        string         tag;
    } item_t;

    item_t sb[$];
    int checks = 0, fails = 0;
    logic [31:0] m_dis = FIX;
    logic [3:0]  m_tgt = '0;
    bit done = 0;

    function automatic logic [NV-1:0] model_vec();
        logic [31:0] en;
        logic [15:0] hw;
        logic [NV-1:0] v;
        en = src & LIVE & ~m_dis;
        hw = '0;
        v  = '0;
        if (!m_dis[31]) begin
            for (int j = 0; j < 32; j++) if (en[j]) hw[TBL[j]] = 1'b1;
        end
        v[m_tgt*16 +: 16] = hw;
        return v;
    endfunction

    task automatic push(int k, logic [2:0] s, logic [NV-1:0] e, string t);
        item_t it;
        it.kind = k; it.rsel = s; it.exp = e; it.tag = t;
        sb.push_back(it);
    endtask

    task automatic push_all(string t);
        push(0, 3'd0, model_vec(), t);
        push(1, 3'd0, NV'(|(src & L15)), t);
        push(2, 3'd0, NV'(src & LIVE), t);
        push(2, 3'd1, NV'(m_dis & WM), t);
        push(2, 3'd4, NV'(m_tgt), t);
    endtask

    task automatic settle_check(string t);
        repeat (2) @(posedge clk);
        #1;
        push_all(t);
        @(negedge clk);
        #4;
    endtask

    task automatic reg_write(logic [2:0] s, logic [31:0] d);
        sel = s; wdata = d; we = 1'b1;
        @(posedge clk);
        #1;
        we = 1'b0;
        case (s)
            3'd2: m_dis = m_dis & ~(d & WM);
            3'd3: m_dis = m_dis | (d & WM);
            3'd4: m_tgt = d[3:0];
            default: ;
        endcase
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                item_t it;
                logic [NV-1:0] got;
                it = sb.pop_front();
                case (it.kind)
                    0: got = lvl;
                    1: got = NV'(bcast);
                    default: begin
                        sel = it.rsel;
                        #1;
                        got = NV'(rdata);
                    end
                endcase
                checks++;
                if (got !== it.exp) begin
                    fails++;
                    $display("FAIL %s kind=%0d off=%0d got=%h exp=%h",
                             it.tag, it.kind, it.rsel, got, it.exp);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        #4;
        settle_check("R10 reset state");

        src = 32'h0000_0080;
        settle_check("R7 R1 single source level 2");

        src = 32'h0015_FF80;
        settle_check("R7 several sources ORed");

        src = 32'h8780_0000;
        settle_check("R1 R2 level-less sources never pending");

        src = 32'h0000_007F;
        reg_write(3'd2, 32'hFFFF_FFFF);
        settle_check("R3 fixed-disabled sources stay blocked");

        src = 32'h0000_0F80;
        reg_write(3'd3, 32'hFFFF_FFFF);
        settle_check("R9 R5 master disable keeps pending");

        reg_write(3'd2, 32'h8000_0000);
        settle_check("R4 master cleared sources still masked");

        reg_write(3'd2, 32'h0000_0200);
        settle_check("R4 enable source 9");

        reg_write(3'd4, 32'hFFFF_FFF5);
        settle_check("R6 R8 retarget to cpu 5");

        src = 32'h7000_0200;
        settle_check("R11 level-15 broadcast while disabled");

        reg_write(3'd2, 32'h1000_0000);
        settle_check("R7 level 15 enabled");

        reg_write(3'd5, 32'hFFFF_FFFF);
        reg_write(3'd6, 32'hFFFF_FFFF);
        reg_write(3'd7, 32'hFFFF_FFFF);
        repeat (2) @(posedge clk);
        #1;
        push_all("R12 undefined writes change nothing");
        push(2, 3'd5, '0, "R12 undefined read 5");
        push(2, 3'd6, '0, "R12 undefined read 6");
        push(2, 3'd7, '0, "R12 undefined read 7");
        @(negedge clk);
        #4;

        src = 32'h0;
        settle_check("R1 release all sources");

        @(negedge clk);
        #4;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule